// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit takes one fetched 32-bit instruction word, the address it was fetched from, and the two operand values the register file has already supplied. It decides whether the word is one of the four supported compare-and-branch operations and, if so, whether the condition holds. It then produces the address of the next instruction to fetch. A taken branch whose target does not fall on a 4-byte boundary raises an exception flag, and the misaligned address is passed on unchanged for the trap logic to see.

The compare is resolved by one less-than comparator. A control bit picks signed or unsigned operation, and a second bit inverts the result to give the greater-or-equal forms. An unsigned less-or-equal test needs no opcode of its own: the caller issues the unsigned greater-or-equal branch with the two operands exchanged. The result can go through one register stage or be taken straight from the combinational path, chosen by a parameter. The default uses the register stage.

Top module: `brn_resolve`

## Requirements
- R1: The instruction word carries the opcode in bits 5:0 and a 16-bit immediate in bits 21:6. Bits 31:27 and 26:22 hold register indices that do not affect any output.
- R2: Opcode 0x16 branches when operand A is less than operand B, both read as signed two's-complement 32-bit values.
- R3: Opcode 0x36 branches when operand A is less than operand B, both read as unsigned 32-bit values.
- R4: Opcode 0x0E branches when A >= B signed. Opcode 0x2E branches when A >= B unsigned. Equal operands take both of these and neither less-than form.
- R5: When taken, the next address is the current address plus 4 plus the sign-extended immediate, wrapping modulo 2^32.
- R6: When not taken, the next address is the current address plus 4, wrapping modulo 2^32.
- R7: For any other opcode the valid-branch output is 0, taken is 0, the misaligned flag is 0, and the next address is the current address plus 4.
- R8: When taken and the target's two low bits are not both zero, the misaligned flag is 1 and the next address holds that target untruncated.
- R9: The misaligned flag is 0 whenever the branch is not taken, even if the immediate's low bits are nonzero.
- R10: Issuing opcode 0x2E with operand A and operand B exchanged gives unsigned A <= B. Equal values take the branch.
- R11: With the register stage on, the outputs change one clock after the inputs. While the active-low reset is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| insn_i | input | 32 | Fetched instruction word |
| pc_i | input | 32 | Address of that instruction |
| opa_i | input | 32 | Value of register operand A |
| opb_i | input | 32 | Value of register operand B |
| taken_o | output | 1 | Branch condition holds |
| next_pc_o | output | 32 | Address of the next instruction |
| is_branch_o | output | 1 | Opcode is one of the supported branches |
| misalign_o | output | 1 | Taken target is not word aligned |

## Verification
The bench pairs the most negative and most positive 32-bit values, and all-ones against zero. A comparator wired with the wrong signedness gives the opposite answer on these pairs. Equal operands separate the strict forms from the inclusive ones, and they also catch an inversion placed on the wrong path. Offsets of +0x7FFC and -0x8000, and an address that wraps past the top of memory, expose a zero-extended immediate or a missing +4. Offsets with nonzero low bits, tried on both taken and not-taken branches, catch a flag that ignores the condition or a target that gets silently rounded down. Unknown opcodes with operands that would branch check that nothing leaks through the decode.

// File: rtl/brn_pkg.sv
package brn_pkg;
    localparam int BRN_XLEN  = 32;
    localparam int BRN_IMM_W = 16;
    localparam int BRN_OPC_W = 6;
    localparam int BRN_IDX_W = 5;
    localparam int BRN_INSN_W = BRN_OPC_W + BRN_IMM_W + 2 * BRN_IDX_W;
    localparam int BRN_IMM_LO = BRN_OPC_W;
    localparam int BRN_IMM_HI = BRN_OPC_W + BRN_IMM_W - 1;

    typedef struct packed {
        logic is_br;
        logic uns;
        logic inv;
    } brn_ctl_t;

    typedef struct packed {
        logic                is_br;
        logic                taken;
        logic                misalign;
        logic [BRN_XLEN-1:0] next_pc;
    } brn_res_t;
endpackage

// File: rtl/brn_decode.sv
module brn_decode
    import brn_pkg::*;
#(
    parameter logic [BRN_OPC_W-1:0] OPC_BLT  = 6'h16,
    parameter logic [BRN_OPC_W-1:0] OPC_BLTU = 6'h36,
    parameter logic [BRN_OPC_W-1:0] OPC_BGE  = 6'h0E,
    parameter logic [BRN_OPC_W-1:0] OPC_BGEU = 6'h2E
) (
    input  logic [BRN_OPC_W-1:0] opc_i,
    output brn_ctl_t             ctl_o
);
    localparam int NOPS = 4;
    // index bit 0 selects unsigned, index bit 1 selects inversion
    localparam logic [BRN_OPC_W-1:0] OPS [NOPS] = '{OPC_BLT, OPC_BLTU, OPC_BGE, OPC_BGEU};

    always_comb begin
        ctl_o = '0;
        for (int i = 0; i < NOPS; i++) begin
            if (opc_i == OPS[i]) begin
                ctl_o.is_br = 1'b1;
                ctl_o.uns   = (i % 2) == 1;
                ctl_o.inv   = i >= 2;
            end
        end
    end
endmodule

// File: rtl/brn_compare.sv
module brn_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         uns_i,
    input  logic         inv_i,
    output logic         cond_o
);
    logic lt_s, lt_u;

    always_comb begin
        lt_s   = $signed(a_i) < $signed(b_i);
        lt_u   = a_i < b_i;
        cond_o = (uns_i ? lt_u : lt_s) ^ inv_i;
    end

    // R2/R3: with equal sign bits the two comparisons must agree
    always_comb begin
        if (!$isunknown({a_i, b_i}) && (a_i[W-1] == b_i[W-1])) begin
            p_sign_agree_r3: assert (lt_s == lt_u);
        end
    end
endmodule

// File: rtl/brn_target.sv
module brn_target #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     pc_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             take_i,
    output logic [W-1:0]     next_pc_o,
    output logic             misalign_o
);
    localparam int          EXT_W = W - IMM_W;
    localparam logic [W-1:0] STEP = W'(4);

    logic [W-1:0] seq_pc, offset, tgt_pc;

    always_comb begin
        seq_pc     = pc_i + STEP;
        offset     = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        tgt_pc     = seq_pc + offset;
        next_pc_o  = take_i ? tgt_pc : seq_pc;
        misalign_o = take_i & (|tgt_pc[1:0]);
    end
endmodule

// File: rtl/brn_resolve.sv
module brn_resolve
    import brn_pkg::*;
#(
    parameter bit                   REG_OUT  = 1'b1,
    parameter logic [BRN_OPC_W-1:0] OPC_BLT  = 6'h16,
    parameter logic [BRN_OPC_W-1:0] OPC_BLTU = 6'h36,
    parameter logic [BRN_OPC_W-1:0] OPC_BGE  = 6'h0E,
    parameter logic [BRN_OPC_W-1:0] OPC_BGEU = 6'h2E
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BRN_INSN_W-1:0] insn_i,
    input  logic [BRN_XLEN-1:0]   pc_i,
    input  logic [BRN_XLEN-1:0]   opa_i,
    input  logic [BRN_XLEN-1:0]   opb_i,
    output logic                  taken_o,
    output logic [BRN_XLEN-1:0]   next_pc_o,
    output logic                  is_branch_o,
    output logic                  misalign_o
);
    localparam int IDX_LO = BRN_IMM_HI + 1;

    brn_ctl_t             ctl;
    logic                 cond;
    logic                 take;
    logic [BRN_XLEN-1:0]  nxt;
    logic                 mis;
    logic [BRN_IMM_W-1:0] imm;
    brn_res_t             res_d, res_q, res_out;
    logic                 unused_idx;

    assign imm        = insn_i[BRN_IMM_HI:BRN_IMM_LO];
    assign unused_idx = ^insn_i[BRN_INSN_W-1:IDX_LO];
    assign take       = ctl.is_br & cond;

    brn_decode #(
        .OPC_BLT (OPC_BLT),
        .OPC_BLTU(OPC_BLTU),
        .OPC_BGE (OPC_BGE),
        .OPC_BGEU(OPC_BGEU)
    ) u_dec (
        .opc_i(insn_i[BRN_OPC_W-1:0]),
        .ctl_o(ctl)
    );

    brn_compare #(.W(BRN_XLEN)) u_cmp (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .uns_i (ctl.uns),
        .inv_i (ctl.inv),
        .cond_o(cond)
    );

    brn_target #(.W(BRN_XLEN), .IMM_W(BRN_IMM_W)) u_tgt (
        .pc_i      (pc_i),
        .imm_i     (imm),
        .take_i    (take),
        .next_pc_o (nxt),
        .misalign_o(mis)
    );

    always_comb begin
        res_d          = '0;
        res_d.is_br    = ctl.is_br;
        res_d.taken    = take;
        res_d.misalign = mis;
        res_d.next_pc  = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    generate
        if (REG_OUT) begin : g_reg
            assign res_out = res_q;

            p_taken_needs_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
                taken_o |-> is_branch_o);
            p_misalign_only_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
                misalign_o |-> taken_o);
            p_misalign_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
                taken_o |-> (misalign_o == (next_pc_o[1:0] != 2'b00)));
            p_fallthrough_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (is_branch_o && !taken_o) |=> 1'b1 ##0
                ($past(next_pc_o) == $past(pc_i, 2) + BRN_XLEN'(4)));
            p_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
                taken_o |-> (next_pc_o == $past(pc_i) + BRN_XLEN'(4)
                    + {{(BRN_XLEN-BRN_IMM_W){$past(insn_i[BRN_IMM_HI])}},
                       $past(insn_i[BRN_IMM_HI:BRN_IMM_LO])}));
        end else begin : g_comb
            assign res_out = res_d;
        end
    endgenerate

    assign taken_o     = res_out.taken;
    assign next_pc_o   = res_out.next_pc;
    assign is_branch_o = res_out.is_br;
    assign misalign_o  = res_out.misalign;
endmodule

// File: tb/sim_brn_resolve.sv
module sim_brn_resolve;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] OP_BLT  = 6'h16;
    localparam logic [5:0] OP_BLTU = 6'h36;
    localparam logic [5:0] OP_BGE  = 6'h0E;
    localparam logic [5:0] OP_BGEU = 6'h2E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_i = '0, pc_i = '0, opa_i = '0, opb_i = '0;
    logic        taken_o, is_branch_o, misalign_o;
    logic [31:0] next_pc_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brn_resolve u0 (
        .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .pc_i(pc_i),
        .opa_i(opa_i), .opb_i(opb_i), .taken_o(taken_o),
        .next_pc_o(next_pc_o), .is_branch_o(is_branch_o), .misalign_o(misalign_o)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [5:0] op, logic [15:0] imm, logic [31:0] pc,
                         logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        insn_i = {5'd9, 5'd17, imm, op};
        pc_i = pc; opa_i = a; opb_i = b;
    endtask

    // drive, wait one register stage, compare every output
    task automatic run_case(string req, logic [5:0] op, logic [15:0] imm,
                            logic [31:0] pc, logic [31:0] a, logic [31:0] b,
                            bit exp_taken);
        logic [31:0] tgt, exp_next;
        bit known, exp_mis;
        known = (op == OP_BLT) || (op == OP_BLTU) || (op == OP_BGE) || (op == OP_BGEU);
        tgt = pc + 32'd4 + {{16{imm[15]}}, imm};
        exp_next = exp_taken ? tgt : pc + 32'd4;
        exp_mis = exp_taken && (tgt[1:0] != 2'b00);
        drive(op, imm, pc, a, b);
        @(negedge clk);
        check(req, "is_branch", {31'd0, is_branch_o}, {31'd0, known});
        check(req, "taken", {31'd0, taken_o}, {31'd0, exp_taken});
        check(req, "next_pc", next_pc_o, exp_next);
        check(req, "misalign", {31'd0, misalign_o}, {31'd0, exp_mis});
    endtask

    task automatic t_reset;  // R11
        insn_i = {5'd1, 5'd2, 16'h0010, OP_BLT};
        pc_i = 32'h100; opa_i = 32'd1; opb_i = 32'd2;
        repeat (3) @(negedge clk);
        check("R11", "reset taken", {31'd0, taken_o}, 32'd0);
        check("R11", "reset next_pc", next_pc_o, 32'd0);
        check("R11", "reset is_branch", {31'd0, is_branch_o}, 32'd0);
        check("R11", "reset misalign", {31'd0, misalign_o}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_signed_lt;  // R2
        run_case("R2", OP_BLT, 16'h0020, 32'h1000, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1);
        run_case("R2", OP_BLT, 16'h0020, 32'h1000, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0);
        run_case("R2", OP_BLT, 16'h0020, 32'h1000, 32'hFFFF_FFFF, 32'h0, 1'b1);
        run_case("R2", OP_BLT, 16'h0020, 32'h1000, 32'h1234, 32'h1234, 1'b0);
    endtask

    task automatic t_unsigned_lt;  // R3
        run_case("R3", OP_BLTU, 16'h0040, 32'h2000, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
        run_case("R3", OP_BLTU, 16'h0040, 32'h2000, 32'h0, 32'hFFFF_FFFF, 1'b1);
        run_case("R3", OP_BLTU, 16'h0040, 32'h2000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_ge;  // R4
        run_case("R4", OP_BGE, 16'h0008, 32'h3000, 32'h55, 32'h55, 1'b1);
        run_case("R4", OP_BGE, 16'h0008, 32'h3000, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
        run_case("R4", OP_BGEU, 16'h0008, 32'h3000, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1);
        run_case("R4", OP_BGEU, 16'h0008, 32'h3000, 32'h0, 32'hFFFF_FFFF, 1'b0);
        run_case("R4", OP_BGEU, 16'h0008, 32'h3000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_le_swapped;  // R10: A<=B issued as BGEU B,A
        run_case("R10", OP_BGEU, 16'h0010, 32'h4000, 32'd5, 32'd5, 1'b1);
        run_case("R10", OP_BGEU, 16'h0010, 32'h4000, 32'd5, 32'hFFFF_FFFF, 1'b0);
        run_case("R10", OP_BGEU, 16'h0010, 32'h4000, 32'hFFFF_FFFF, 32'd5, 1'b1);
    endtask

    task automatic t_offsets;  // R5 R6 R1
        run_case("R5", OP_BLT, 16'h7FFC, 32'h0000_1000, 32'd0, 32'd1, 1'b1);
        check("R5", "max positive target", next_pc_o, 32'h0000_9000);
        run_case("R5", OP_BLT, 16'h8000, 32'h0001_0000, 32'd0, 32'd1, 1'b1);
        check("R5", "max negative target", next_pc_o, 32'h0000_8004);
        run_case("R6", OP_BLT, 16'h8000, 32'hFFFF_FFFC, 32'd1, 32'd0, 1'b0);
        check("R6", "wrap fallthrough", next_pc_o, 32'h0000_0000);
        // R1: register index bits change, nothing else does
        @(negedge clk);
        insn_i = {5'd31, 5'd0, 16'h0100, OP_BLT};
        pc_i = 32'h500; opa_i = 32'd0; opb_i = 32'd1;
        @(negedge clk);
        check("R1", "imm from 21:6", next_pc_o, 32'h0000_0604);
        insn_i[31:22] = 10'h2AA;
        @(negedge clk);
        check("R1", "index bits ignored", next_pc_o, 32'h0000_0604);
        check("R1", "index bits ignored taken", {31'd0, taken_o}, 32'd1);
    endtask

    task automatic t_misalign;  // R8 R9
        run_case("R8", OP_BGE, 16'h0002, 32'h0000_0800, 32'd3, 32'd3, 1'b1);
        check("R8", "untruncated target", next_pc_o, 32'h0000_0806);
        run_case("R8", OP_BLTU, 16'hFFFF, 32'h0000_0800, 32'd0, 32'd9, 1'b1);
        check("R8", "odd negative target", next_pc_o, 32'h0000_0803);
        run_case("R9", OP_BLT, 16'h0001, 32'h0000_0800, 32'd9, 32'd0, 1'b0);
        check("R9", "no flag when not taken", {31'd0, misalign_o}, 32'd0);
    endtask

    task automatic t_unknown;  // R7
        run_case("R7", 6'h00, 16'h0003, 32'h0000_0900, 32'd0, 32'd1, 1'b0);
        run_case("R7", 6'h3F, 16'h0040, 32'h0000_0900, 32'h8000_0000, 32'd0, 1'b0);
        run_case("R7", 6'h17, 16'h0040, 32'h0000_0900, 32'd0, 32'd1, 1'b0);
    endtask

    task automatic t_latency;  // R11
        run_case("R11", OP_BLT, 16'h0010, 32'h0000_0A00, 32'd0, 32'd1, 1'b1);
        drive(OP_BLT, 16'h0010, 32'h0000_0B00, 32'd1, 32'd0);
        #1;
        check("R11", "held before edge", next_pc_o, 32'h0000_0A14);
        check("R11", "taken held before edge", {31'd0, taken_o}, 32'd1);
        @(negedge clk);
        check("R11", "updated after edge", next_pc_o, 32'h0000_0B04);
    endtask

    initial begin
        t_reset();
        t_signed_lt();
        t_unsigned_lt();
        t_ge();
        t_le_swapped();
        t_offsets();
        t_misalign();
        t_unknown();
        t_latency();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule